// File: doc/BRIEF.md
# Serial DAC Input Register Core

This block is the digital front end of a 12-bit serial-input converter. It runs on a fast system clock and oversamples three slow serial lines: a data line, a serial clock and an active-low select/commit strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When the strobe returns high, the shift register is copied into a holding register. The holding register drives the parallel code that the converter uses.

The top bit of the shift register is driven out as a serial output, so several devices can be chained, with all of them sharing the serial clock and the strobe. An active-low clear input zeros the shift register and the holding register at once, without waiting for a clock edge. The power-on reset has the same effect. The release of either one is aligned to the system clock.

A control state machine has four states. `ST_HOLD`: the strobe is high and serial clocks have no effect. `ST_WAIT_LO`: the strobe is low and the machine waits for the serial clock to rise. `ST_CLK_HI`: the strobe is low and the machine waits for the serial clock to fall. `ST_LOAD`: a single cycle in which the holding register is written.

The transitions are as follows. `HOLD->WAIT_LO`: the strobe falls while the serial clock is low. `HOLD->CLK_HI`: the strobe falls while the serial clock is high, which gives one extra shift. `WAIT_LO->CLK_HI`: the serial clock rises, which gives a shift. `CLK_HI->WAIT_LO`: the serial clock falls. `WAIT_LO/CLK_HI->LOAD`: the strobe rises. `LOAD->HOLD`: always taken.

Top module: `sdac_input_core`

## Requirements
- R1: While the strobe is low, each rising serial clock shifts the data line into bit 0 of the 12-bit shift register, with the older bits moving toward bit 11. A word is therefore sent most significant bit first, and after 12 clocks bit 11 holds the first bit sent.
- R2: While the strobe is high, serial clock edges leave the shift register unchanged.
- R3: A rising edge of the strobe copies the shift register into the holding register, and `dac_code` shows the new value.
- R4: When `clr_n` is low, `dac_code`, the shift register and `sdo` are forced to zero at once, without any clock edge.
- R5: After `rst_n` is released, `dac_code` is 0 and `sdo` is 0.
- R6: `sdo` equals bit 11 of the shift register and changes with each shift. After a 13th bit is sent, `sdo` shows the second bit of the previous word.
- R7: If the strobe falls while the serial clock is high, exactly one shift takes place, using the data line's value at that time.
- R8: Words are received correctly when the serial clock stays high and low for 2 system clocks each, which is a system clock four times the serial rate.
- R9: While the strobe stays high and no serial clocks arrive, `dac_code` stays the same for as long as this lasts.
- R10: A second rising edge of the strobe with no serial clocks in between loads the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low power-on reset |
| clr_n | input | 1 | Active-low asynchronous clear |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select; its rising edge commits the word |
| sdo | output | 1 | Chain output, bit 11 of the shift register |
| dac_code | output | DATA_W | Holding register, the parallel code |

## Verification
The hardest case to reach is the strobe falling while the serial clock is already high. The bench has to raise the serial clock during the idle period with the strobe high, and confirm that this causes no shift. It then lowers the strobe with the clock still high and commits without any further clock. The committed code must show exactly one extra bit shifted in. The asynchronous clear is checked between clock edges, so that the zeroing does not depend on a clock edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_CLK_HI  = 2'd2,
        ST_LOAD    = 2'd3
    } sdac_state_e;
endpackage

// File: rtl/sdac_rst_sync.sv
// Asynchronous assertion, clocked release of the internal reset.
module sdac_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_out_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_sync.sv
// Multi-stage synchroniser for a bundle of slow inputs.
module sdac_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_ctrl.sv
// Strobe / serial clock state machine.
module sdac_ctrl
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sclk_s,
    output logic shift_en,
    output logic load_en,
    output logic in_hold
);
    sdac_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!cs_s) state_d = sclk_s ? ST_CLK_HI : ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (cs_s)        state_d = ST_LOAD;
                else if (sclk_s) state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (cs_s)         state_d = ST_LOAD;
                else if (!sclk_s) state_d = ST_WAIT_LO;
            end
            ST_LOAD: state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        in_hold  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                in_hold  = 1'b1;
                // strobe falling with the clock high yields one extra shift
                shift_en = !cs_s && sclk_s;
            end
            ST_WAIT_LO: shift_en = !cs_s && sclk_s;
            ST_CLK_HI:  shift_en = 1'b0;
            ST_LOAD:    load_en  = 1'b1;
            default:    in_hold  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdac_datapath.sv
// Shift register and holding register.
module sdac_datapath #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] shreg_q,
    output logic [DATA_W-1:0] hold_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[DATA_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (load_en) hold_q <= shreg_q;
    end
endmodule

// File: rtl/sdac_input_core.sv
module sdac_input_core #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int RST_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sdi,
    input  logic              sclk,
    input  logic              cs_n,
    output logic              sdo,
    output logic [DATA_W-1:0] dac_code
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] LINE_RST = 3'b100; // {cs, sclk, sdi}

    logic              areset_n;
    logic              raw_clr_n;
    logic [LINES-1:0]  lines_s;
    logic              cs_s, sclk_s, din_s;
    logic              shift_en, load_en, in_hold;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] hold_q;

    assign raw_clr_n = rst_n & clr_n;

    sdac_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk       (clk),
        .arst_n    (raw_clr_n),
        .rst_out_n (areset_n)
    );

    sdac_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL(LINE_RST)) u_sync (
        .clk   (clk),
        .rst_n (areset_n),
        .din   ({cs_n, sclk, sdi}),
        .dout  (lines_s)
    );

    assign {cs_s, sclk_s, din_s} = lines_s;

    sdac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (areset_n),
        .cs_s     (cs_s),
        .sclk_s   (sclk_s),
        .shift_en (shift_en),
        .load_en  (load_en),
        .in_hold  (in_hold)
    );

    sdac_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (areset_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .bit_in   (din_s),
        .shreg_q  (shreg_q),
        .hold_q   (hold_q)
    );

    assign sdo      = shreg_q[DATA_W-1];
    assign dac_code = hold_q;
endmodule

// File: rtl/sdac_input_core_chk.sv
module sdac_input_core_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              areset_n,
    input logic              cs_s,
    input logic              din_s,
    input logic              shift_en,
    input logic              load_en,
    input logic              in_hold,
    input logic [DATA_W-1:0] shreg_q,
    input logic              sdo,
    input logic [DATA_W-1:0] dac_code
);
    AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (!areset_n)
        shift_en |=> shreg_q[0] == $past(din_s)); // R1
    AST_IGNORE_WHEN_HIGH: assert property (@(posedge clk) disable iff (!areset_n)
        (in_hold && cs_s) |-> !shift_en); // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!areset_n)
        load_en |=> dac_code == $past(shreg_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == '0 && shreg_q == '0 && !sdo)); // R4
    AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!areset_n)
        shift_en |=> sdo == $past(shreg_q[DATA_W-2])); // R6
    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!areset_n)
        !load_en |=> $stable(dac_code)); // R9
endmodule

bind sdac_input_core sdac_input_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .areset_n (areset_n),
    .cs_s     (cs_s),
    .din_s    (din_s),
    .shift_en (shift_en),
    .load_en  (load_en),
    .in_hold  (in_hold),
    .shreg_q  (shreg_q),
    .sdo      (sdo),
    .dac_code (dac_code)
);

// File: tb/sdac_input_core_bench.sv
module sdac_input_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;
    localparam int NVEC = 6;
    localparam logic [W-1:0] VEC_IN  [NVEC] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h3C6, 12'h7FE};
    localparam logic [W-1:0] VEC_EXP [NVEC] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h3C6, 12'h7FE};

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr_n = 1'b1, sdi = 1'b0, sclk = 1'b0, cs_n = 1'b1;
    logic sdo;
    logic [W-1:0] dac_code;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_input_core u_sdac_input_core (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sdi(sdi),
        .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .dac_code(dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, input int half);
        sdi = b;
        tick(half);
        sclk = 1'b1;
        tick(half);
        sclk = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] w, input int half);
        cs_n = 1'b0;
        tick(3);
        for (int i = W-1; i >= 0; i--) clk_bit(w[i], half);
        tick(2);
    endtask

    task automatic commit();
        cs_n = 1'b1;
        tick(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        check("R5 code", dac_code, 0);
        check("R5 sdo", sdo, 0);

        // table of words, MSB first (R1, R3, R6)
        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC_IN[v], 4);
            check("R6 sdo after word", sdo, VEC_EXP[v][W-1]);
            commit();
            check("R1 R3 code", dac_code, VEC_EXP[v]);
        end

        // chaining: 13th bit pushes out second bit of previous word (R6)
        send_word(12'hA5C, 4);
        clk_bit(1'b1, 4);
        tick(4);
        check("R6 chained sdo", sdo, 0);
        commit();
        check("R1 thirteen-bit code", dac_code, 12'h4B9);

        // clocks while strobe high are ignored (R2), reload same word (R10)
        sdi = 1'b1;
        for (int k = 0; k < 4; k++) clk_bit(1'b1, 4);
        tick(4);
        check("R2 sdo unchanged", sdo, 0);
        cs_n = 1'b0;
        tick(6);
        commit();
        check("R2 R10 reload same word", dac_code, 12'h4B9);

        // hold stable (R9)
        tick(300);
        check("R9 hold stable", dac_code, 12'h4B9);

        // strobe falls while serial clock high: one extra shift (R7)
        sdi = 1'b1;
        sclk = 1'b1;
        tick(6);
        cs_n = 1'b0;
        tick(6);
        sclk = 1'b0;
        tick(4);
        commit();
        check("R7 extra shift", dac_code, 12'h973);

        // 4x oversampling margin (R8)
        send_word(12'hED2, 2);
        commit();
        check("R8 fast serial clock", dac_code, 12'hED2);
        check("R8 sdo", sdo, 1);

        // asynchronous clear between edges (R4)
        clr_n = 1'b0;
        #1;
        check("R4 code async", dac_code, 0);
        check("R4 sdo async", sdo, 0);
        tick(3);
        clr_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(6);
        commit();
        check("R4 shift reg cleared", dac_code, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule